// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers interrupt requests from one non-maskable input, eight external request lines and sixteen keyboard-style inputs, and presents one winning request, with its vector number and vector address, to the processor. Each of the eight maskable lines has a pending flag and an enable bit. Every line can be set to catch rising edges or to follow its level. Two processor mask bits, here called `cpu_i` and `cpu_ui`, decide which requests are accepted.

Priority works in two steps. First, a control register assigns each line to level 1 or level 0. Several lines share one bit of that register. Second, within a level, the line with the lower vector number wins. The non-maskable input beats everything and ignores all masks and enables. The winner is held, with its vector, until the processor acknowledges it. The acknowledge clears the flag of an edge-caught source. Software clears level flags by writing zeros.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Each line i has a flag, visible on `irq_flag[i]`. If `irq_edge[i]`=1, a rising edge of the line sets the flag. If `irq_edge[i]`=0, the flag is set in every cycle the line is high. The flag is then visible one clock after the input changes.
- R2: A maskable line can win only when both its flag and its `irq_en` bit are 1.
- R3: A cycle with `flag_wr`=1 clears every flag whose `flag_wdata` bit is 0 and leaves the flags whose bit is 1 unchanged. A set condition in the same cycle wins over the clear.
- R4: Any high bit of `key_pin[7:0]` acts as line 6 being high. Any high bit of `key_pin[15:8]` acts as line 7 being high.
- R5: The level of each line is taken from `ctrl_lvl` as follows: line 0 from bit 7, line 1 from bit 6, lines 2–3 from bit 5, lines 4–5 from bit 4, and lines 6–7 from bit 3.
- R6: The mask bits gate maskable lines as follows:
  - `cpu_i`=0 accepts every enabled line.
  - `cpu_i`=1 with `cpu_ui`=0 accepts only level-1 lines.
  - `cpu_i`=1 with `cpu_ui`=1 accepts no maskable line.
- R7: Priority order is: the non-maskable request first, then accepted level-1 lines, then accepted level-0 lines. Within a level, the lowest line index wins.
- R8: Vector numbers are assigned as follows:
  - The non-maskable request uses vector number 7.
  - Line i uses vector number 16+i when `ext_mode`=0, and 64+i when `ext_mode`=1.
- R9: `vec_addr` equals the vector number times 4.
- R10: The winner is latched one clock after it becomes eligible, and `irq_req` rises at that point. From then until acknowledge, `irq_req` stays 1 and `vec_num` stays unchanged, even if a higher-priority request arrives.
- R11: When `ack`=1 while `irq_req`=1, `irq_req` drops on the next clock. The same acknowledge clears the flag of the winning line if that line is edge-caught, or clears the non-maskable pending state. Flags of level lines are left set.
- R12: After reset, `irq_req`=0 and all flags are 0.
- R13: A rising edge of `nmi_pin` is accepted whatever the mask bits and enables are. It produces vector number 7 at address 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_pin | input | 1 | Non-maskable request input, rising-edge caught |
| irq_pin | input | 8 | External request lines |
| key_pin | input | 16 | Keyboard inputs; the low half is grouped onto line 6, the high half onto line 7 |
| irq_edge | input | 8 | Per-line sense select: 1 = rising edge, 0 = level |
| irq_en | input | 8 | Per-line enable |
| ctrl_lvl | input | 8 | Control-level register (bits 7..3 used) |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 8 | Flag write data; a 0 bit clears that flag |
| cpu_i | input | 1 | Processor mask bit I |
| cpu_ui | input | 1 | Processor mask bit UI |
| ext_mode | input | 1 | Selects the extended vector table |
| ack | input | 1 | Processor acknowledge |
| irq_req | output | 1 | Request to the processor |
| vec_num | output | 8 | Vector number of the held winner |
| vec_addr | output | 24 | Vector address of the held winner |
| irq_flag | output | 8 | Pending flags |

## Verification
Assertions check the following on every cycle:
- the held request and vector stay stable until acknowledge;
- an acknowledge drops the request;
- a pending non-maskable request is always the one latched next;
- no maskable request rises while both mask bits are set, or without an enabled flag behind it.

Some behaviour only the bench scenarios can show. These are the following:
- the exact winner across sweeps of line, enable, control-level and mask patterns;
- the control-level bit mapping;
- the key grouping;
- the extended vector numbers;
- the difference between edge and level flags on acknowledge;
- the set-over-clear rule of the flag write.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NIRQ     = 8,
  parameter int KEY_W    = 16,
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 24,
  parameter int NMI_VEC  = 7,
  parameter int IRQ_BASE = 16,
  parameter int EXT_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pin,
  input  logic [NIRQ-1:0]   irq_pin,
  input  logic [KEY_W-1:0]  key_pin,
  input  logic [NIRQ-1:0]   irq_edge,
  input  logic [NIRQ-1:0]   irq_en,
  input  logic [7:0]        ctrl_lvl,
  input  logic              flag_wr,
  input  logic [NIRQ-1:0]   flag_wdata,
  input  logic              cpu_i,
  input  logic              cpu_ui,
  input  logic              ext_mode,
  input  logic              ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  vec_num,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [NIRQ-1:0]   irq_flag
);
  localparam int IDX_W  = $clog2(NIRQ);
  localparam int HALF_K = KEY_W / 2;

  logic [NIRQ-1:0]  pin_eff, pin_q, set_v, wr_clr, ack_clr, flag;
  logic [NIRQ-1:0]  lvl1, active, acc_hi, acc_lo, pool;
  logic             nmi_q, nmi_pend, held, held_nmi, take, acked;
  logic [IDX_W-1:0] held_idx, win_idx;
  logic [VEC_W-1:0] held_vec;

  function automatic logic [IDX_W-1:0] lowest(input logic [NIRQ-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  always_comb begin
    pin_eff = irq_pin;
    pin_eff[6] = irq_pin[6] | (|key_pin[HALF_K-1:0]);
    pin_eff[7] = irq_pin[7] | (|key_pin[KEY_W-1:HALF_K]);
  end

  assign set_v   = (irq_edge & pin_eff & ~pin_q) | (~irq_edge & pin_eff);
  assign wr_clr  = flag_wr ? ~flag_wdata : '0;
  assign acked   = ack & held;
  assign ack_clr = (acked && !held_nmi) ? (irq_edge & (NIRQ'(1) << held_idx)) : '0;

  assign lvl1 = {ctrl_lvl[3], ctrl_lvl[3], ctrl_lvl[4], ctrl_lvl[4],
                 ctrl_lvl[5], ctrl_lvl[5], ctrl_lvl[6], ctrl_lvl[7]};

  assign active  = flag & irq_en;
  assign acc_hi  = active & lvl1 & {NIRQ{!(cpu_i && cpu_ui)}};
  assign acc_lo  = active & ~lvl1 & {NIRQ{!cpu_i}};
  assign pool    = (|acc_hi) ? acc_hi : acc_lo;
  assign win_idx = lowest(pool);
  assign take    = !held && (nmi_pend || (|pool));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= '0;
      nmi_q    <= 1'b0;
      flag     <= '0;
      nmi_pend <= 1'b0;
    end else begin
      pin_q    <= pin_eff;
      nmi_q    <= nmi_pin;
      flag     <= (flag & ~wr_clr & ~ack_clr) | set_v;
      nmi_pend <= (nmi_pin & ~nmi_q) | (nmi_pend & ~(acked & held_nmi));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_nmi <= 1'b0;
      held_idx <= '0;
      held_vec <= '0;
    end else if (acked) begin
      held <= 1'b0;
    end else if (take) begin
      held     <= 1'b1;
      held_nmi <= nmi_pend;
      held_idx <= win_idx;
      if (nmi_pend) held_vec <= VEC_W'(NMI_VEC);
      else held_vec <= (ext_mode ? VEC_W'(EXT_BASE) : VEC_W'(IRQ_BASE)) + VEC_W'(win_idx);
    end
  end

  assign irq_req  = held;
  assign vec_num  = held_vec;
  assign vec_addr = ADDR_W'(held_vec) << 2;
  assign irq_flag = flag;

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !ack |=> irq_req && $stable(vec_num));

  // R11
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && ack |=> !irq_req);

  // R13
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && nmi_pend |=> irq_req && vec_num == VEC_W'(NMI_VEC));

  // R6
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) && vec_num != VEC_W'(NMI_VEC) |-> !$past(cpu_i && cpu_ui));

  // R2
  need_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) && vec_num != VEC_W'(NMI_VEC) |-> $past(|(irq_flag & irq_en)));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, nmi_pin = 0, flag_wr = 0, cpu_i = 0, cpu_ui = 0, ext_mode = 0, ack = 0;
  logic [7:0]  irq_pin = 0, irq_edge = 0, irq_en = 0, ctrl_lvl = 0, flag_wdata = 0;
  logic [15:0] key_pin = 0;
  logic        irq_req;
  logic [7:0]  vec_num, irq_flag;
  logic [23:0] vec_addr;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  prio_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin), .key_pin(key_pin),
    .irq_edge(irq_edge), .irq_en(irq_en), .ctrl_lvl(ctrl_lvl), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .cpu_i(cpu_i), .cpu_ui(cpu_ui), .ext_mode(ext_mode), .ack(ack), .irq_req(irq_req),
    .vec_num(vec_num), .vec_addr(vec_addr), .irq_flag(irq_flag));

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic bit lvl_of(input int idx, input logic [7:0] l);
    case (idx)
      0: return l[7];
      1: return l[6];
      2, 3: return l[5];
      4, 5: return l[4];
      default: return l[3];
    endcase
  endfunction

  function automatic int model(input logic [7:0] p, e, l, input bit i, ui);
    int best = -1;
    for (int k = 7; k >= 0; k--)
      if (p[k] && e[k] && !(i && ui) && lvl_of(k, l)) best = k;
    if (best < 0 && !i)
      for (int k = 7; k >= 0; k--)
        if (p[k] && e[k] && !lvl_of(k, l)) best = k;
    return best;
  endfunction

  task automatic cleanup();
    irq_pin = 0; key_pin = 0; nmi_pin = 0; flag_wr = 1; flag_wdata = 0;
    tick();
    flag_wr = 0; ack = irq_req;
    tick();
    ack = 0;
    tick();
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    // R12 reset state
    chk(irq_req == 0, "R12 irq_req after reset", irq_req, 0);
    chk(irq_flag == 0, "R12 flags after reset", irq_flag, 0);
    rst_n = 1;
    tick();

    // R2 R5 R6 R7 R8 R9 sweep of level-mode patterns
    for (int p = 0; p < 256; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] e, l;
        int w, ev;
        e = 8'((p * 29 + m * 71 + 13) & 255);
        l = 8'((p * 53 + m * 17) & 255);
        irq_pin = 8'(p); irq_en = e; ctrl_lvl = l;
        cpu_i = m[1]; cpu_ui = m[0]; ext_mode = p[1];
        tick(2);
        w = model(8'(p), e, l, m[1], m[0]);
        ev = (p[1] ? 64 : 16) + w;
        chk(irq_req == (w >= 0), "R2/R6 request presence", irq_req, w >= 0);
        if (w >= 0) begin
          chk(vec_num == 8'(ev), "R5/R7/R8 winner vector", vec_num, ev);
          chk(vec_addr == 24'(ev * 4), "R9 vector address", vec_addr, ev * 4);
        end
        cleanup();
      end
    end
    cpu_i = 0; cpu_ui = 0; ext_mode = 0; ctrl_lvl = 0; irq_en = 8'hFF;

    // R1 R11 edge-mode flag cleared by ack
    irq_edge = 8'h08; irq_pin = 8'h08;
    tick();
    irq_pin = 0;
    chk(irq_flag == 8'h08, "R1 edge flag set", irq_flag, 8);
    tick();
    chk(irq_req && vec_num == 19, "R1 edge request vec", vec_num, 19);
    ack = 1; tick(); ack = 0;
    chk(!irq_req, "R11 req drops after ack", irq_req, 0);
    chk(irq_flag == 0, "R11 edge flag cleared by ack", irq_flag, 0);
    tick(2);
    chk(!irq_req, "R1 no retrigger without new edge", irq_req, 0);
    irq_edge = 0;

    // R11 level flag kept after ack
    irq_pin = 8'h02; tick(2);
    chk(vec_num == 17, "R11 level vec", vec_num, 17);
    ack = 1; tick(); ack = 0;
    chk(!irq_req, "R11 level req drops", irq_req, 0);
    chk(irq_flag[1] == 1, "R11 level flag kept", irq_flag[1], 1);
    cleanup();

    // R10 hold against a later higher request
    irq_pin = 8'h20; tick(2);
    chk(vec_num == 21, "R10 first winner", vec_num, 21);
    irq_pin = 8'h21; tick(3);
    chk(irq_req && vec_num == 21, "R10 vector held", vec_num, 21);
    irq_pin = 8'h01; flag_wr = 1; flag_wdata = 8'hDF; tick();
    flag_wr = 0; ack = 1; tick(); ack = 0; tick();
    chk(irq_req && vec_num == 16, "R10 next winner after ack", vec_num, 16);
    cleanup();

    // R3 write-zero clear, write-one keep, set beats clear
    irq_en = 0; irq_pin = 8'h04; tick(); irq_pin = 0;
    flag_wr = 1; flag_wdata = 8'hFF; tick();
    chk(irq_flag == 8'h04, "R3 write one keeps flag", irq_flag, 4);
    flag_wdata = 8'hFB; tick();
    chk(irq_flag == 0, "R3 write zero clears flag", irq_flag, 0);
    irq_pin = 8'h10; flag_wdata = 8'h00; tick();
    chk(irq_flag == 8'h10, "R3 set wins over clear", irq_flag, 16);
    flag_wr = 0; irq_en = 8'hFF;
    cleanup();

    // R4 key groups
    key_pin = 16'h0008; tick(2);
    chk(irq_flag == 8'h40, "R4 low key group flag", irq_flag, 64);
    chk(vec_num == 22, "R4 low key group vector", vec_num, 22);
    cleanup();
    key_pin = 16'h1000; tick(2);
    chk(vec_num == 23 && irq_req, "R4 high key group vector", vec_num, 23);
    cleanup();

    // R13 NMI bypasses masks and enables
    cpu_i = 1; cpu_ui = 1; irq_en = 0; irq_pin = 8'hFF;
    nmi_pin = 1; tick(); nmi_pin = 0; tick();
    chk(irq_req && vec_num == 7, "R13 nmi vector", vec_num, 7);
    chk(vec_addr == 24'h1C, "R13 nmi address", vec_addr, 28);
    ack = 1; tick(); ack = 0; tick(2);
    chk(!irq_req, "R13 nmi cleared by ack, rest masked", irq_req, 0);
    cleanup();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule